// File: doc/BRIEF.md
# Boot Entry Sequencer

This block owns the way a processor core enters execution after a reset. It takes the raw, asynchronous, active-low reset request from the board pin and synchronizes it. It accepts the request only once the line has stayed low for a minimum number of clock cycles. A glitch or a short dip on the pin therefore leaves a running core undisturbed.

While a reset is accepted, the block keeps the core parked. It drives fixed start values onto the stack pointer and the status fields, holds the program counter at zero, and puts the address strobe pin into high impedance. Once the pin returns high, the block reads a three-byte start vector from the top of the address space over a simple request/acknowledge byte port. It assembles the 24-bit start address least significant byte first and then pulses a start signal for one cycle. A new reset accepted during the vector read abandons the read, and the whole sequence begins again after release.

A separate power-on reset input clears the block's own flops. That power-on reset counts as an accepted reset, so the sequence runs once after power-up without any pin activity.

Top module: `boot_sequencer`

## Requirements
- R1: A reset is accepted when the synchronized pin has been sampled low on at least MIN_LOW (default 10) consecutive clock edges. An accepted reset is always followed, after the pin is released, by a new vector read and a new start pulse.
- R2: A low pulse shorter than MIN_LOW cycles is ignored: no byte request, no start pulse, and pc, ale_oe and the status outputs keep their values.
- R3: While a reset is accepted and held, the stack pointer output equals 0x100.
- R4: While a reset is accepted and held, sr_imask = 3'b111, sr_max = 1 and sr_bank = 3'b000.
- R5: ale_oe is 0 (strobe pin in high impedance) while a reset is accepted, and 1 once the sequencer has left the held state.
- R6: After release the vector bytes are read one request at a time at addresses 0xFFFF00, 0xFFFF01 and 0xFFFF02, in that order. rd_req stays high with rd_addr stable until rd_ack is seen.
- R7: pc[7:0], pc[15:8] and pc[23:16] come from the bytes read at 0xFFFF00, 0xFFFF01 and 0xFFFF02 respectively. While held, pc reads zero.
- R8: core_start is high for exactly one cycle, the cycle after the third byte is acknowledged, with pc already holding the assembled address.
- R9: A reset accepted during the vector read cancels it with no start pulse. After release, the read restarts from 0xFFFF00.
- R10: After power-on reset the block behaves as if a reset had been accepted, and starts the vector read once ext_rst_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| pwr_rst_n | input | 1 | Power-on reset for the block's own flops, active low, asynchronous |
| ext_rst_n | input | 1 | Asynchronous reset request pin, active low, filtered |
| rd_req | output | 1 | Byte read request |
| rd_addr | output | 24 | Byte read address |
| rd_ack | input | 1 | Byte read acknowledge, data valid in the same cycle |
| rd_data | input | 8 | Byte read data |
| pc | output | 24 | Start program counter |
| xsp | output | 32 | Stack pointer start value |
| sr_imask | output | 3 | Interrupt mask level field |
| sr_max | output | 1 | Mode bit (1 = maximum mode) |
| sr_bank | output | 3 | Register bank select field |
| ale_oe | output | 1 | Output enable of the address strobe pin (0 = high impedance) |
| core_start | output | 1 | One-cycle pulse telling the core to begin fetching |

## Verification
The bench builds the block with its defaults: a two-stage synchronizer, MIN_LOW of 10, a three-byte vector at 0xFFFF00 and a 32-bit stack pointer. With MIN_LOW this small, pulses of 9 and 10 low cycles sit on either side of the acceptance edge and can be driven directly. Random pulse lengths just above the limit are also exercised. The byte responder inserts random acknowledge delays. A slow responder mode stretches one byte read long enough for a second accepted reset to land inside the vector read and abort it.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;
  typedef enum logic [1:0] {
    ST_HELD  = 2'd0,
    ST_FETCH = 2'd1,
    ST_GO    = 2'd2,
    ST_RUN   = 2'd3
  } seq_state_t;
endpackage

// File: rtl/boot_rst_sync.sv
module boot_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic pin_sync
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sh_d = pin_n;
    end else begin : g_many
      always_comb sh_d = {sh_q[STAGES-2:0], pin_n};
    end
  endgenerate

  // Reset value low: the block starts as if the pin were asserted.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign pin_sync = sh_q[STAGES-1];
endmodule

// File: rtl/boot_low_filter.sv
module boot_low_filter #(
  parameter int MIN_LOW = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_sync,
  output logic accept
);
  localparam int CW = $clog2(MIN_LOW + 1);
  localparam logic [CW-1:0] LIMIT = CW'(MIN_LOW);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (pin_sync)            cnt_d = '0;
    else if (cnt_q != LIMIT) cnt_d = cnt_q + 1'b1;
  end

  // Power-on counts as an accepted reset (R10).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= LIMIT;
    else        cnt_q <= cnt_d;
  end

  assign accept = (cnt_q == LIMIT);

  p_accept_after_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(accept) |-> $past(!pin_sync));
  p_high_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pin_sync |=> !accept);
endmodule

// File: rtl/boot_vec_fetch.sv
module boot_vec_fetch
  import boot_seq_pkg::*;
#(
  parameter int              ADDR_W    = 24,
  parameter int              VEC_BYTES = 3,
  parameter logic [ADDR_W-1:0] VEC_BASE = 24'hFFFF00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ack,
  input  logic [7:0]        rd_data,
  output logic [ADDR_W-1:0] pc,
  output logic              start,
  output logic              held
);
  localparam int IW = (VEC_BYTES > 1) ? $clog2(VEC_BYTES) : 1;
  localparam logic [IW-1:0] LAST = IW'(VEC_BYTES - 1);

  seq_state_t        state_q, state_d;
  logic [IW-1:0]     idx_q, idx_d;
  logic [ADDR_W-1:0] pc_q, pc_d;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    pc_d    = pc_q;
    case (state_q)
      ST_HELD: begin
        pc_d  = '0;
        idx_d = '0;
        if (!accept) state_d = ST_FETCH;
      end
      ST_FETCH: begin
        if (rd_ack) begin
          for (int b = 0; b < VEC_BYTES; b++)
            if (idx_q == IW'(b)) pc_d[8*b +: 8] = rd_data;
          if (idx_q == LAST) state_d = ST_GO;
          else               idx_d   = idx_q + 1'b1;
        end
      end
      ST_GO:   state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
    if (accept) begin
      state_d = ST_HELD;
      idx_d   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HELD;
      idx_q   <= '0;
      pc_q    <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      pc_q    <= pc_d;
    end
  end

  assign rd_req  = (state_q == ST_FETCH);
  assign rd_addr = VEC_BASE + ADDR_W'(idx_q);
  assign pc      = pc_q;
  assign start   = (state_q == ST_GO);
  assign held    = (state_q == ST_HELD);

  p_req_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack && !accept) |=> (rd_req && $stable(rd_addr)));
  p_start_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!start && !rd_req));
  p_start_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> $past(rd_req && rd_ack && (rd_addr == VEC_BASE + ADDR_W'(VEC_BYTES - 1))));
  p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!rd_req && !start));
  p_pc_zero_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (held && $past(held)) |-> (pc == '0));
endmodule

// File: rtl/boot_arch_init.sv
module boot_arch_init #(
  parameter int              SP_W    = 32,
  parameter logic [SP_W-1:0] SP_INIT = 32'h0000_0100
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            held,
  output logic [SP_W-1:0] xsp,
  output logic [2:0]      sr_imask,
  output logic            sr_max,
  output logic [2:0]      sr_bank
);
  logic [SP_W-1:0] xsp_q, xsp_d;
  logic [2:0]      imask_q, imask_d, bank_q, bank_d;
  logic            max_q, max_d;

  always_comb begin
    xsp_d   = xsp_q;
    imask_d = imask_q;
    bank_d  = bank_q;
    max_d   = max_q;
    if (held) begin
      xsp_d   = SP_INIT;
      imask_d = 3'b111;
      bank_d  = 3'b000;
      max_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xsp_q   <= SP_INIT;
      imask_q <= 3'b111;
      bank_q  <= 3'b000;
      max_q   <= 1'b1;
    end else begin
      xsp_q   <= xsp_d;
      imask_q <= imask_d;
      bank_q  <= bank_d;
      max_q   <= max_d;
    end
  end

  assign xsp      = xsp_q;
  assign sr_imask = imask_q;
  assign sr_max   = max_q;
  assign sr_bank  = bank_q;
endmodule

// File: rtl/boot_sequencer.sv
module boot_sequencer #(
  parameter int                SYNC_STAGES = 2,
  parameter int                MIN_LOW     = 10,
  parameter int                ADDR_W      = 24,
  parameter int                VEC_BYTES   = 3,
  parameter logic [ADDR_W-1:0] VEC_BASE    = 24'hFFFF00,
  parameter int                SP_W        = 32,
  parameter logic [SP_W-1:0]   SP_INIT     = 32'h0000_0100
) (
  input  logic              clk,
  input  logic              pwr_rst_n,
  input  logic              ext_rst_n,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ack,
  input  logic [7:0]        rd_data,
  output logic [ADDR_W-1:0] pc,
  output logic [SP_W-1:0]   xsp,
  output logic [2:0]        sr_imask,
  output logic              sr_max,
  output logic [2:0]        sr_bank,
  output logic              ale_oe,
  output logic              core_start
);
  logic pin_sync;
  logic accept;
  logic held;

  boot_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(pwr_rst_n), .pin_n(ext_rst_n), .pin_sync(pin_sync)
  );

  boot_low_filter #(.MIN_LOW(MIN_LOW)) u_filter (
    .clk(clk), .rst_n(pwr_rst_n), .pin_sync(pin_sync), .accept(accept)
  );

  boot_vec_fetch #(.ADDR_W(ADDR_W), .VEC_BYTES(VEC_BYTES), .VEC_BASE(VEC_BASE)) u_fetch (
    .clk(clk), .rst_n(pwr_rst_n), .accept(accept),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .pc(pc), .start(core_start), .held(held)
  );

  boot_arch_init #(.SP_W(SP_W), .SP_INIT(SP_INIT)) u_init (
    .clk(clk), .rst_n(pwr_rst_n), .held(held),
    .xsp(xsp), .sr_imask(sr_imask), .sr_max(sr_max), .sr_bank(sr_bank)
  );

  assign ale_oe = !held;

  p_ale_hiz_r5: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    accept |=> !ale_oe);
  p_init_regs_r3_r4: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    held |=> (xsp == SP_INIT && sr_imask == 3'b111 && sr_max && sr_bank == 3'b000));
endmodule

// File: tb/boot_sequencer_tb.sv
module boot_sequencer_tb;
  logic        clk;
  logic        pwr_rst_n;
  logic        ext_rst_n;
  logic        rd_req;
  logic [23:0] rd_addr;
  logic        rd_ack;
  logic [7:0]  rd_data;
  logic [23:0] pc;
  logic [31:0] xsp;
  logic [2:0]  sr_imask;
  logic        sr_max;
  logic [2:0]  sr_bank;
  logic        ale_oe;
  logic        core_start;

  int errors = 0;
  int checks = 0;
  int start_cnt = 0;
  int ack_cnt = 0;
  int req_seen = 0;
  bit slow = 0;
  bit prev_start = 0;
  int dly = 0;
  logic [7:0]  vec [3];
  logic [23:0] a0, a1, a2;

  boot_sequencer u_dut (
    .clk(clk), .pwr_rst_n(pwr_rst_n), .ext_rst_n(ext_rst_n),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .pc(pc), .xsp(xsp), .sr_imask(sr_imask), .sr_max(sr_max), .sr_bank(sr_bank),
    .ale_oe(ale_oe), .core_start(core_start)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  function automatic logic [23:0] exp_pc();
    return {vec[2], vec[1], vec[0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Byte responder and monitor, all at the falling edge.
  always @(negedge clk) begin
    if (rd_req) req_seen++;
    if (rd_ack) rd_ack = 1'b0;
    else if (rd_req) begin
      if (dly == 0) begin
        rd_ack  = 1'b1;
        rd_data = vec[rd_addr[1:0]];
        a0 = a1; a1 = a2; a2 = rd_addr;
        ack_cnt++;
        dly = slow ? 40 : int'($urandom % 4);
      end else dly--;
    end
    if (core_start) begin
      start_cnt++;
      chk(!prev_start, "R8 start width one cycle", 1, 0);
      chk({a0, a1, a2} == {24'hFFFF00, 24'hFFFF01, 24'hFFFF02}, "R6 vector address order",
          {a0[7:0], a1[7:0], a2[7:0]}, 24'h000102);
      chk(pc == exp_pc(), "R7 pc assembled little-endian", pc, exp_pc());
    end
    prev_start = core_start;
  end

  task automatic wait_start(input int prev, input string tag);
    int n = 0;
    while (start_cnt == prev && n < 500) begin
      @(negedge clk);
      n++;
    end
    chk(start_cnt == prev + 1, tag, start_cnt, prev + 1);
  endtask

  task automatic pulse(input int len);
    @(negedge clk);
    ext_rst_n = 1'b0;
    repeat (len) @(negedge clk);
    ext_rst_n = 1'b1;
  endtask

  task automatic check_held(input string tag);
    chk(ale_oe == 1'b0, {"R5 ale high-Z held ", tag}, ale_oe, 0);
    chk(xsp == 32'h100, {"R3 xsp held ", tag}, xsp, 32'h100);
    chk({sr_imask, sr_max, sr_bank} == 7'b111_1_000, {"R4 status held ", tag},
        {sr_imask, sr_max, sr_bank}, 7'b1111000);
    chk(pc == 24'h0 && !rd_req, {"R7 pc zero, no request while held ", tag}, pc, 0);
  endtask

  initial begin
    int s;
    int len;
    void'($urandom(32'h5EED_0042));
    rd_ack = 0; rd_data = 0;
    pwr_rst_n = 0; ext_rst_n = 1;
    vec[0] = 8'h34; vec[1] = 8'h12; vec[2] = 8'hFE;
    repeat (3) @(negedge clk);
    check_held("power-on R10");
    chk(!core_start, "R10 no start during power-on", core_start, 0);
    pwr_rst_n = 1;
    wait_start(0, "R10 start after power-on");
    @(negedge clk);
    chk(ale_oe == 1'b1, "R5 ale enabled after release", ale_oe, 1);

    // Short pulse: ignored.
    s = start_cnt; req_seen = 0;
    ext_rst_n = 0;
    repeat (9) begin
      @(negedge clk);
      chk(ale_oe == 1'b1, "R2 ale unchanged on short pulse", ale_oe, 1);
    end
    ext_rst_n = 1;
    repeat (30) @(negedge clk);
    chk(req_seen == 0 && start_cnt == s, "R2 short pulse no fetch", req_seen, 0);
    chk(pc == exp_pc(), "R2 pc kept on short pulse", pc, exp_pc());
    chk(xsp == 32'h100 && sr_imask == 3'b111, "R2 status kept", xsp, 32'h100);

    // Exactly the minimum width: accepted.
    vec[0] = 8'hA5; vec[1] = 8'h5A; vec[2] = 8'h01;
    s = start_cnt;
    pulse(10);
    wait_start(s, "R1 ten-cycle pulse accepted");

    // Long hold, observe held values.
    vec[0] = 8'h00; vec[1] = 8'hFF; vec[2] = 8'h80;
    s = start_cnt;
    @(negedge clk); ext_rst_n = 0;
    repeat (16) @(negedge clk);
    check_held("long");
    ext_rst_n = 1;
    wait_start(s, "R1 long pulse restarts");

    // Abort during the vector read.
    slow = 1;
    s = start_cnt;
    @(negedge clk); ext_rst_n = 0;
    repeat (14) @(negedge clk);
    ext_rst_n = 1;
    begin
      int a = ack_cnt;
      int n = 0;
      while (ack_cnt == a && n < 200) begin @(negedge clk); n++; end
    end
    ext_rst_n = 0;
    repeat (16) @(negedge clk);
    chk(start_cnt == s, "R9 aborted read gives no start", start_cnt, s);
    check_held("abort R9");
    slow = 0; dly = 0;
    vec[0] = 8'h11; vec[1] = 8'h22; vec[2] = 8'h33;
    ext_rst_n = 1;
    wait_start(s, "R9 restart after abort");

    // Random pulses and vectors.
    for (int i = 0; i < 8; i++) begin
      for (int b = 0; b < 3; b++) vec[b] = 8'($urandom);
      len = 10 + int'($urandom % 20);
      s = start_cnt;
      pulse(len);
      wait_start(s, "R1 random pulse accepted");
    end

    repeat (5) @(negedge clk);
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
  end
endmodule